// File: doc/BRIEF.md
# Four-Class 32-bit ALU

This is the combinational arithmetic/logic unit of a small load/store processor core. It takes two 32-bit operands, `x` and `y`, and a function code split into separate fields. A two-bit class field routes one of four internal units to the result. The four units are a barrel shifter that acts on `y`, a signed set-less-than unit, a shared add/subtract unit and a bitwise logic unit. The other fields select add or subtract, pick the logic operation, pick the shift kind and say where the shift amount comes from.

A zero flag is derived from whichever result is selected. The overflow flag always reports the adder's signed overflow. Set-less-than reuses the adder in subtract mode instead of a separate comparator, and corrects the adder's sign bit with the overflow condition. Load-upper-immediate needs no extra unit: the immediate enters as `y` and is shifted left by a constant 16.

Top module: `alu4c`

## Requirements
- R1: `fn_class` selects the result: 2'b00 shifter, 2'b01 set-less-than, 2'b10 adder, 2'b11 logic unit.
- R2: In class 2'b10, `add_sub`=0 gives `x + y` and `add_sub`=1 gives `x - y`, both modulo 2^32.
- R3: `ovfl` is 1 exactly when the adder's operation is outside the signed 32-bit range. That operation is `x + y`, or `x - y` when `add_sub`=1 or when the class is 2'b01. This holds in every class.
- R4: In class 2'b01 the result is 1 when signed `x` < signed `y` and 0 otherwise, with bits 31..1 zero. The result stays correct when the subtraction overflows.
- R5: In class 2'b11, `logic_fn` 2'b00 gives AND, 2'b01 OR, 2'b10 XOR and 2'b11 NOR of `x` and `y`.
- R6: In class 2'b00, `shift_fn` 2'b00 passes `y` unchanged, 2'b01 shifts `y` left logically, 2'b10 shifts it right logically and 2'b11 shifts it right arithmetically.
- R7: `amt_var`=0 takes the shift amount from `amt_const`. `amt_var`=1 takes it from `x[4:0]`, and the upper bits of `x` have no effect on the amount. An amount of 0 leaves `y` unchanged.
- R8: `zero` is 1 exactly when all 32 bits of `result` are 0, whatever the class.
- R9: Load-upper-immediate works as class 2'b00 with `shift_fn`=2'b01, `amt_var`=0 and `amt_const`=16, and gives `y << 16`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | 32 | First operand; its low 5 bits can supply the shift amount |
| y | input | 32 | Second operand; the value that gets shifted |
| add_sub | input | 1 | 0 add, 1 subtract (subtract is forced in class 2'b01) |
| logic_fn | input | 2 | Bitwise operation select |
| shift_fn | input | 2 | Shift kind select |
| amt_var | input | 1 | 0 constant amount, 1 amount from x |
| amt_const | input | 5 | Constant shift amount |
| fn_class | input | 2 | Result class select |
| result | output | 32 | Selected result |
| zero | output | 1 | Result is all zeros |
| ovfl | output | 1 | Adder signed overflow |

## Verification
The block has no registers, so every output is due in the same cycle as the operand and function code that produce it, zero clock edges later. The bench changes inputs on the falling clock edge and samples one nanosecond later, so the logic has settled and no rising edge lies in between. A table of hand-computed vectors covers each class and the corner cases. A sweep over pseudo-random operands then compares every function code with a reference that computes overflow in a wider signed range.

// File: rtl/alu4c_pkg.sv
// alu4c_pkg: encodings shared by the four-class ALU units.
// Assumes: field encodings are fixed by the instruction decoder upstream.
package alu4c_pkg;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_SLT   = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_LOGIC = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOR = 2'b11
    } logic_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_LSL  = 2'b01,
        SH_LSR  = 2'b10,
        SH_ASR  = 2'b11
    } shift_e;

endpackage

// File: rtl/alu4c_addsub.sv
// alu4c_addsub: one W-bit adder that also subtracts by inverting b and
// forcing the carry-in. Reports signed two's-complement overflow.
// Assumes: purely combinational; caller picks sub.
module alu4c_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovfl
);

    logic [W-1:0] b_eff;

    // Invert b, add with carry-in, and flag a sign mismatch as overflow.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        ovfl  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    // Compare the sum with the plain arithmetic reference and check the flag.
    always_comb begin
        // R2
        addsub_sum_chk: assert (sum == (sub ? (a - b) : (a + b)))
            else $error("adder sum mismatch");
        // R3
        addsub_ovfl_chk: assert (!ovfl || (sum[W-1] != a[W-1]))
            else $error("overflow flagged without sign change");
    end

endmodule

// File: rtl/alu4c_shifter.sv
// alu4c_shifter: logarithmic barrel shifter. One generated stage per bit of
// the amount; the fill bit is the sign for arithmetic right shifts.
// Assumes: W is a power of two and SHW = log2(W).
module alu4c_shifter
    import alu4c_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  shift_e         fn,
    output logic [W-1:0]   dout
);

    logic [W-1:0] stg [0:SHW];
    logic         go_left;
    logic         fill;

    // Decode the direction and the fill bit from the shift kind.
    always_comb begin
        go_left = (fn == SH_LSL);
        fill    = (fn == SH_ASR) & din[W-1];
        stg[0]  = din;
    end

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        // Shift by 2^k when bit k of the amount is set.
        always_comb begin
            if (!amt[k])
                stg[k+1] = stg[k];
            else if (go_left)
                stg[k+1] = {stg[k][W-1-D:0], {D{1'b0}}};
            else
                stg[k+1] = {{D{fill}}, stg[k][W-1:D]};
        end
    end

    // A zero shift kind passes the input untouched.
    always_comb begin
        dout = (fn == SH_NONE) ? din : stg[SHW];
    end

    // Compare the stage chain with the language shift operators.
    always_comb begin
        // R6
        shift_none_chk: assert (fn != SH_NONE || dout == din)
            else $error("no-shift changed data");
        // R6
        shift_lsl_chk: assert (fn != SH_LSL || dout == (din << amt))
            else $error("left shift mismatch");
        // R6
        shift_lsr_chk: assert (fn != SH_LSR || dout == (din >> amt))
            else $error("logical right shift mismatch");
        // R6
        shift_asr_chk: assert (fn != SH_ASR || dout == W'($signed(din) >>> amt))
            else $error("arithmetic right shift mismatch");
    end

endmodule

// File: rtl/alu4c_logic.sv
// alu4c_logic: bitwise AND / OR / XOR / NOR of two W-bit words.
// Assumes: purely combinational.
module alu4c_logic
    import alu4c_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_e       fn,
    output logic [W-1:0] y
);

    // Pick the bitwise operation.
    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end

    // Check the outputs through algebraic identities.
    always_comb begin
        // R5
        logic_xor_chk: assert (fn != LG_XOR || (y ^ b) == a)
            else $error("xor identity broken");
        // R5
        logic_nor_chk: assert (fn != LG_NOR || ((y & (a | b)) == '0 && (y | a | b) == '1))
            else $error("nor identity broken");
    end

endmodule

// File: rtl/alu4c.sv
// alu4c: four-class ALU top. It selects the shift amount source, shares one
// adder between arithmetic and set-less-than, and muxes the class result.
// It then derives the zero flag.
// Assumes: combinational; the set-less-than class forces the adder to subtract.
module alu4c
    import alu4c_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           add_sub,
    input  logic [1:0]     logic_fn,
    input  logic [1:0]     shift_fn,
    input  logic           amt_var,
    input  logic [SHW-1:0] amt_const,
    input  logic [1:0]     fn_class,
    output logic [W-1:0]   result,
    output logic           zero,
    output logic           ovfl
);

    cls_e           cls;
    logic [SHW-1:0] amt;
    logic           do_sub;
    logic [W-1:0]   sum;
    logic [W-1:0]   sh_out;
    logic [W-1:0]   lg_out;
    logic           less;

    // Decode the class, the amount source and the adder mode.
    always_comb begin
        cls    = cls_e'(fn_class);
        amt    = amt_var ? x[SHW-1:0] : amt_const;
        do_sub = add_sub | (cls == CLS_SLT);
    end

    alu4c_addsub #(.W(W)) u_add (
        .a    (x),
        .b    (y),
        .sub  (do_sub),
        .sum  (sum),
        .ovfl (ovfl)
    );

    alu4c_shifter #(.W(W), .SHW(SHW)) u_shift (
        .din  (y),
        .amt  (amt),
        .fn   (shift_e'(shift_fn)),
        .dout (sh_out)
    );

    alu4c_logic #(.W(W)) u_logic (
        .a  (x),
        .b  (y),
        .fn (logic_e'(logic_fn)),
        .y  (lg_out)
    );

    // Correct the adder sign bit with overflow to get a signed less-than.
    always_comb begin
        less = sum[W-1] ^ ovfl;
    end

    // Route the selected class to the result and form the zero flag.
    always_comb begin
        unique case (cls)
            CLS_SHIFT: result = sh_out;
            CLS_SLT:   result = {{(W-1){1'b0}}, less};
            CLS_ARITH: result = sum;
            default:   result = lg_out;
        endcase
        zero = ~|result;
    end

    // Check top-level results against independent operators.
    always_comb begin
        // R4
        slt_cmp_chk: assert (cls != CLS_SLT || result == {{(W-1){1'b0}}, ($signed(x) < $signed(y))})
            else $error("set-less-than mismatch");
        // R1
        class_and_chk: assert (!(cls == CLS_LOGIC && logic_fn == 2'b00) || result == (x & y))
            else $error("logic class routing mismatch");
        // R8
        zero_flag_chk: assert (zero == ($countones(result) == 0))
            else $error("zero flag mismatch");
    end

endmodule

// File: tb/alu4c_test.sv
// alu4c_test: table of hand-worked vectors, then directed and swept checks
// against a reference model.
module alu4c_test;

    typedef struct packed {
        logic [1:0]  cls;
        logic        sub;
        logic [1:0]  lfn;
        logic [1:0]  sfn;
        logic        vr;
        logic [4:0]  cam;
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] res;
        logic        z;
        logic        o;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        // R1 R2 add
        '{2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0, 32'd5, 32'd7, 32'd12, 1'b0, 1'b0, 4'd2},
        // R2 subtract to negative
        '{2'b10, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0, 32'd5, 32'd7, 32'hFFFF_FFFE, 1'b0, 1'b0, 4'd2},
        // R3 add overflow
        '{2'b10, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 1'b0, 1'b1, 4'd3},
        // R3 subtract overflow
        '{2'b10, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd3},
        // R8 equal operands subtract to zero
        '{2'b10, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0, 32'd1234, 32'd1234, 32'd0, 1'b1, 1'b0, 4'd8},
        // R4 -1 < 1
        '{2'b01, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0, 32'hFFFF_FFFF, 32'd1, 32'd1, 1'b0, 1'b0, 4'd4},
        // R4 most negative < 1, subtraction overflows
        '{2'b01, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0, 32'h8000_0000, 32'd1, 32'd1, 1'b0, 1'b1, 4'd4},
        // R4 most positive not < -1, subtraction overflows
        '{2'b01, 1'b1, 2'b00, 2'b00, 1'b0, 5'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b1, 4'd4},
        // R4 add_sub=0 still subtracts in this class
        '{2'b01, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0, 32'd3, 32'd9, 32'd1, 1'b0, 1'b0, 4'd4},
        // R5 AND
        '{2'b11, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0, 1'b0, 4'd5},
        // R5 OR
        '{2'b11, 1'b0, 2'b01, 2'b00, 1'b0, 5'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0, 1'b0, 1'b0, 4'd5},
        // R5 XOR
        '{2'b11, 1'b0, 2'b10, 2'b00, 1'b0, 5'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0, 1'b0, 4'd5},
        // R5 NOR
        '{2'b11, 1'b0, 2'b11, 2'b00, 1'b0, 5'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h000F_000F, 1'b0, 1'b0, 4'd5},
        // R6 logical left by constant 4
        '{2'b00, 1'b0, 2'b00, 2'b01, 1'b0, 5'd4, 32'd0, 32'h8000_000F, 32'h0000_00F0, 1'b0, 1'b0, 4'd6},
        // R7 logical right by x[4:0]=8, x bit 8 ignored
        '{2'b00, 1'b0, 2'b00, 2'b10, 1'b1, 5'd3, 32'h0000_0108, 32'h8000_0000, 32'h0080_0000, 1'b0, 1'b0, 4'd7},
        // R6 arithmetic right by 4
        '{2'b00, 1'b0, 2'b00, 2'b11, 1'b0, 5'd4, 32'd0, 32'h8000_0000, 32'hF800_0000, 1'b0, 1'b0, 4'd6},
        // R6 R8 arithmetic right of positive value by 31
        '{2'b00, 1'b0, 2'b00, 2'b11, 1'b0, 5'd31, 32'd0, 32'h4000_0000, 32'd0, 1'b1, 1'b0, 4'd6},
        // R9 load upper immediate
        '{2'b00, 1'b0, 2'b00, 2'b01, 1'b0, 5'd16, 32'd0, 32'h0000_ABCD, 32'hABCD_0000, 1'b0, 1'b0, 4'd9},
        // R7 shift amount 0 leaves y
        '{2'b00, 1'b0, 2'b00, 2'b01, 1'b0, 5'd0, 32'd0, 32'h0000_1234, 32'h0000_1234, 1'b0, 1'b0, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] x, y;
    logic        add_sub, amt_var;
    logic [1:0]  logic_fn, shift_fn, fn_class;
    logic [4:0]  amt_const;
    logic [31:0] result;
    logic        zero, ovfl;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    alu4c uut (
        .x(x), .y(y), .add_sub(add_sub), .logic_fn(logic_fn),
        .shift_fn(shift_fn), .amt_var(amt_var), .amt_const(amt_const),
        .fn_class(fn_class), .result(result), .zero(zero), .ovfl(ovfl)
    );

    task automatic chk(input int req, input logic [31:0] er, input logic ez, input logic eo);
        checks++;
        if (result !== er || zero !== ez || ovfl !== eo) begin
            errors++;
            $display("FAIL R%0d: result %h zero %b ovfl %b, expected %h %b %b",
                     req, result, zero, ovfl, er, ez, eo);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic s, input logic [1:0] lf,
                         input logic [1:0] sf, input logic v, input logic [4:0] ca,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        fn_class = c; add_sub = s; logic_fn = lf; shift_fn = sf;
        amt_var = v; amt_const = ca; x = a; y = b;
        #1;
    endtask

    // Reference model; overflow is taken from a 64-bit signed result.
    function automatic logic [33:0] model(input logic [1:0] c, input logic s, input logic [1:0] lf,
                                          input logic [1:0] sf, input logic v, input logic [4:0] ca,
                                          input logic [31:0] a, input logic [31:0] b);
        logic        sb;
        longint      wide;
        logic [4:0]  n;
        logic [31:0] r;
        logic        o;
        sb   = s | (c == 2'b01);
        wide = sb ? (longint'($signed(a)) - longint'($signed(b)))
                  : (longint'($signed(a)) + longint'($signed(b)));
        o    = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
        n    = v ? a[4:0] : ca;
        case (c)
            2'b00: case (sf)
                       2'b00: r = b;
                       2'b01: r = b << n;
                       2'b10: r = b >> n;
                       default: r = 32'($signed(b) >>> n);
                   endcase
            2'b01: r = {31'd0, $signed(a) < $signed(b)};
            2'b10: r = sb ? a - b : a + b;
            default: case (lf)
                       2'b00: r = a & b;
                       2'b01: r = a | b;
                       2'b10: r = a ^ b;
                       default: r = ~(a | b);
                   endcase
        endcase
        return {r, (r == 32'd0), o};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf_a, lf_b;
        logic [33:0] m;
        x = '0; y = '0; add_sub = 1'b0; logic_fn = '0; shift_fn = '0;
        amt_var = 1'b0; amt_const = '0; fn_class = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R8 idle state under reset: all-zero inputs give zero result, no overflow
        chk(8, 32'd0, 1'b1, 1'b0);
        rst_n = 1'b1;

        // Table walk: covers R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cls, VEC[i].sub, VEC[i].lfn, VEC[i].sfn, VEC[i].vr,
                  VEC[i].cam, VEC[i].x, VEC[i].y);
            chk(int'(VEC[i].req), VEC[i].res, VEC[i].z, VEC[i].o);
        end

        // R3 overflow is reported even while the logic class is selected
        drive(2'b11, 1'b0, 2'b00, 2'b00, 1'b0, 5'd0, 32'h7FFF_FFFF, 32'h0000_0001);
        chk(3, 32'd1, 1'b0, 1'b1);

        // R7 variable amount uses only x[4:0]: x=0xFFFF_FFE0 shifts by 0
        drive(2'b00, 1'b0, 2'b00, 2'b01, 1'b1, 5'd7, 32'hFFFF_FFE0, 32'h0000_0055);
        chk(7, 32'h0000_0055, 1'b0, 1'b0);

        // R1 sweep: every class and sub-function over LFSR operands
        lf_a = 32'h1234_5678; lf_b = 32'h9ABC_DEF1;
        for (int it = 0; it < 48; it++) begin
            for (int c = 0; c < 4; c++) begin
                for (int f = 0; f < 4; f++) begin
                    lf_a = {lf_a[30:0], lf_a[31] ^ lf_a[21] ^ lf_a[1] ^ lf_a[0]};
                    lf_b = {lf_b[30:0], lf_b[31] ^ lf_b[21] ^ lf_b[1] ^ lf_b[0]};
                    if (it == 0) lf_b = lf_a;
                    drive(2'(c), lf_b[3], 2'(f), 2'(f), lf_a[9], lf_b[8:4], lf_a, lf_b);
                    m = model(2'(c), lf_b[3], 2'(f), 2'(f), lf_a[9], lf_b[8:4], lf_a, lf_b);
                    chk(1, m[33:2], m[1], m[0]);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule